// File: doc/BRIEF.md
# Packet Transmit Framer

This block turns bytes taken from a transmit FIFO into the serial bit stream of one radio packet. On a start request it sends alternating-bit preamble bytes, a sync word of two configured bytes (or those two bytes twice in the long sync setting), an optional length byte, the payload and an optional 16-bit checksum. It emits one bit per clock, most significant bit of each byte first, with a valid strobe that stays high without gaps for the whole packet.

The FIFO is read through a show-ahead interface: the head byte and an empty flag are visible at all times, and a one-cycle read pulse consumes the head byte. The preamble keeps repeating until the FIFO has data. Three length modes exist (fixed, length taken from the first FIFO byte, and endless). The mode is sampled at every byte boundary, so software can change an endless packet to fixed length while it is being sent and stop it at a count taken modulo 256. If the FIFO runs dry inside a packet, the framer stops in a sticky underflow state that only a flush clears.

Top module: `txf_framer`

## Requirements
- R1: After reset bit_vld, fifo_rd, sync_sent, pkt_done and underflow are all 0.
- R2: tx_en sampled high while idle starts a packet. Its first bit appears on the next cycle. It opens with max(cfg_pre_bytes,1) preamble bytes of value 0xAA.
- R3: If the FIFO is empty when the preamble count is reached, further 0xAA bytes follow. The sync word starts at the first byte boundary at which the FIFO is not empty.
- R4: The sync word is cfg_sync[15:8] then cfg_sync[7:0]. With cfg_sync_dbl=1 these two bytes are sent twice. sync_sent is high for exactly the one cycle in which the last sync bit is on bit_out.
- R5: cfg_len_mode=0 (fixed) sends exactly cfg_pkt_len payload bytes after the sync word.
- R6: cfg_len_mode=1 (variable) sends the first FIFO byte as a length byte, not counted in the length, followed by that many payload bytes. A length of 0 sends the length byte alone.
- R7: cfg_len_mode=2 (endless) keeps sending FIFO bytes. When the mode is changed to 0 mid-packet, the packet ends after the byte that brings the payload byte count modulo 256 equal to cfg_pkt_len.
- R8: With cfg_crc_en=1, two bytes follow the payload: a CRC-16 (polynomial 0x8005, initial 0xFFFF, MSB-first, not reflected) over every byte read from the FIFO, including a length byte, sent high byte first.
- R9: pkt_done is high for exactly the cycle in which the final bit of the packet is on bit_out. bit_vld is 0 on the following cycle and the framer is idle.
- R10: If a FIFO byte is needed while the FIFO is empty, bit_vld drops and underflow rises and stays high. tx_en and new FIFO data have no effect, and nothing is read, until a flush pulse returns the framer to idle.
- R11: bit_vld is high on every cycle from the first preamble bit to the last bit of the packet.
- R12: fifo_rd pulses once per byte consumed, only while the FIFO is not empty, and the number of pulses equals the number of FIFO bytes in the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one output bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Start request, sampled only while idle |
| flush | input | 1 | Abort and clear underflow, return to idle |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Consume the head byte at this clock edge |
| cfg_pre_bytes | input | PRE_W | Minimum number of preamble bytes |
| cfg_sync | input | 16 | Sync word, high byte sent first |
| cfg_sync_dbl | input | 1 | Send the sync word twice |
| cfg_len_mode | input | 2 | 0 fixed, 1 variable, 2 endless |
| cfg_pkt_len | input | LEN_W | Fixed length or stop count modulo 256 |
| cfg_crc_en | input | 1 | Append the CRC-16 |
| bit_out | output | 1 | Serial data bit |
| bit_vld | output | 1 | bit_out carries a packet bit |
| sync_sent | output | 1 | Last sync bit is on bit_out |
| pkt_done | output | 1 | Last packet bit is on bit_out |
| underflow | output | 1 | Sticky FIFO underflow |

## Verification
The first preamble bit is due on the cycle after the clock edge that sees tx_en. fifo_rd rises in the cycle that carries the last bit of the preceding byte. sync_sent and pkt_done coincide with the bit they mark, and underflow and the drop of bit_vld follow on the next cycle after the last bit sent. The bench captures bit_out at each falling edge while bit_vld is high and indexes each captured bit by its position in the packet. It compares these bits, and the positions at which the two pulses were seen, with a bit image it builds from the configuration and the FIFO bytes. The test that delays the FIFO data writes it during a chosen bit and expects the sync word at the next byte boundary.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_SYNC  = 3'd2,
        PH_LEN   = 3'd3,
        PH_PAY   = 3'd4,
        PH_CRC   = 3'd5,
        PH_UFLOW = 3'd6
    } phase_e;

    localparam logic [1:0] LM_FIXED = 2'd0;
    localparam logic [1:0] LM_VAR   = 2'd1;
    localparam logic [1:0] LM_INF   = 2'd2;

    localparam int         BYTE_W   = 8;
    localparam logic [7:0] PRE_BYTE = 8'hAA;

    // one byte through an MSB-first, non-reflected CRC-16
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly);
        logic [15:0] c;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ din[i]) c = {c[14:0], 1'b0} ^ poly;
            else                c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/txf_crc16.sv
module txf_crc16 #(
    parameter logic [15:0] POLY = 16'h8005,
    parameter logic [15:0] INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import txf_pkg::*;

    typedef struct packed {
        logic [15:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)    st_d.crc = INIT;
        else if (upd) st_d.crc = crc16_step(st_q.crc, din, POLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{crc: INIT};
        else        st_q <= st_d;
    end

    assign crc = st_q.crc;

    // R8: a packet start never coincides with a FIFO byte entering the sum
    a_r8_no_clear_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear && upd));

endmodule

// File: rtl/txf_serializer.sv
module txf_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         run,
    output logic         sdo,
    output logic         last
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        logic [W-1:0]     sh;
        logic [CNT_W-1:0] cnt;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh  = din;
            st_d.cnt = '0;
        end else if (run) begin
            st_d.sh  = {st_q.sh[W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo  = st_q.sh[W-1];
    assign last = (st_q.cnt == CNT_W'(W - 1));

    // R11: while running, a new byte is only taken after the last bit of the current one
    a_r11_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (load && run) |-> last);

endmodule

// File: rtl/txf_framer.sv
module txf_framer #(
    parameter int          PRE_W    = 4,
    parameter int          LEN_W    = 8,
    parameter logic [15:0] CRC_POLY = 16'h8005,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             flush,
    input  logic             fifo_empty,
    input  logic [7:0]       fifo_data,
    output logic             fifo_rd,
    input  logic [PRE_W-1:0] cfg_pre_bytes,
    input  logic [15:0]      cfg_sync,
    input  logic             cfg_sync_dbl,
    input  logic [1:0]       cfg_len_mode,
    input  logic [LEN_W-1:0] cfg_pkt_len,
    input  logic             cfg_crc_en,
    output logic             bit_out,
    output logic             bit_vld,
    output logic             sync_sent,
    output logic             pkt_done,
    output logic             underflow
);
    import txf_pkg::*;

    typedef struct packed {
        phase_e             phase;
        logic [PRE_W-1:0]   pre_cnt;
        logic [1:0]         sync_idx;
        logic [LEN_W-1:0]   pay_cnt;
        logic [LEN_W-1:0]   vlen;
        logic               crc_idx;
    } fr_st_t;

    fr_st_t st_d, st_q;

    logic              ld, pop, crc_clr, done_now, sync_now, take, fin;
    logic [BYTE_W-1:0] ld_byte;
    logic              boundary, ser_last, ser_bit, active;
    logic [1:0]        sync_last;
    logic              pay_end;
    logic [15:0]       crc_val;

    assign active = (st_q.phase == PH_PRE)  || (st_q.phase == PH_SYNC) ||
                    (st_q.phase == PH_LEN)  || (st_q.phase == PH_PAY)  ||
                    (st_q.phase == PH_CRC);
    assign boundary  = active && ser_last;
    assign sync_last = cfg_sync_dbl ? 2'd3 : 2'd1;
    assign pay_end   = ((cfg_len_mode == LM_FIXED) && (st_q.pay_cnt == cfg_pkt_len)) ||
                       ((cfg_len_mode == LM_VAR)   && (st_q.pay_cnt == st_q.vlen));

    always_comb begin
        st_d     = st_q;
        ld       = 1'b0;
        ld_byte  = PRE_BYTE;
        pop      = 1'b0;
        crc_clr  = 1'b0;
        done_now = 1'b0;
        sync_now = 1'b0;
        take     = 1'b0;
        fin      = 1'b0;

        case (st_q.phase)
            PH_IDLE: begin
                if (tx_en) begin
                    ld            = 1'b1;
                    crc_clr       = 1'b1;
                    st_d.phase    = PH_PRE;
                    st_d.pre_cnt  = PRE_W'(1);
                    st_d.sync_idx = '0;
                    st_d.pay_cnt  = '0;
                    st_d.vlen     = '0;
                    st_d.crc_idx  = 1'b0;
                end
            end
            PH_PRE: begin
                if (boundary) begin
                    ld = 1'b1;
                    if (st_q.pre_cnt < cfg_pre_bytes) begin
                        st_d.pre_cnt = st_q.pre_cnt + 1'b1;
                    end else if (!fifo_empty) begin
                        ld_byte       = cfg_sync[15:8];
                        st_d.phase    = PH_SYNC;
                        st_d.sync_idx = '0;
                    end
                end
            end
            PH_SYNC: begin
                if (boundary) begin
                    if (st_q.sync_idx != sync_last) begin
                        st_d.sync_idx = st_q.sync_idx + 1'b1;
                        ld            = 1'b1;
                        ld_byte       = st_d.sync_idx[0] ? cfg_sync[7:0] : cfg_sync[15:8];
                    end else begin
                        sync_now = 1'b1;
                        take     = 1'b1;
                    end
                end
            end
            PH_LEN: begin
                if (boundary) begin
                    if (st_q.vlen == '0) fin  = 1'b1;
                    else                 take = 1'b1;
                end
            end
            PH_PAY: begin
                if (boundary) begin
                    if (pay_end) fin  = 1'b1;
                    else         take = 1'b1;
                end
            end
            PH_CRC: begin
                if (boundary) begin
                    if (!st_q.crc_idx) begin
                        ld           = 1'b1;
                        ld_byte      = crc_val[7:0];
                        st_d.crc_idx = 1'b1;
                    end else begin
                        st_d.phase = PH_IDLE;
                        done_now   = 1'b1;
                    end
                end
            end
            default: ;
        endcase

        // next byte must come from the FIFO
        if (take) begin
            if (fifo_empty) begin
                st_d.phase = PH_UFLOW;
            end else begin
                pop     = 1'b1;
                ld      = 1'b1;
                ld_byte = fifo_data;
                if ((st_q.phase == PH_SYNC) && (cfg_len_mode == LM_VAR)) begin
                    st_d.phase = PH_LEN;
                    st_d.vlen  = LEN_W'(fifo_data);
                end else begin
                    st_d.phase   = PH_PAY;
                    st_d.pay_cnt = st_q.pay_cnt + 1'b1;
                end
            end
        end

        // payload complete: checksum or end of packet
        if (fin) begin
            if (cfg_crc_en) begin
                ld           = 1'b1;
                ld_byte      = crc_val[15:8];
                st_d.phase   = PH_CRC;
                st_d.crc_idx = 1'b0;
            end else begin
                st_d.phase = PH_IDLE;
                done_now   = 1'b1;
            end
        end

        if (flush) begin
            st_d.phase = PH_IDLE;
            ld         = 1'b0;
            pop        = 1'b0;
            crc_clr    = 1'b0;
            done_now   = 1'b0;
            sync_now   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    txf_serializer #(.W(BYTE_W)) u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ld),
        .din  (ld_byte),
        .run  (active),
        .sdo  (ser_bit),
        .last (ser_last)
    );

    txf_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(crc_clr),
        .upd  (pop),
        .din  (fifo_data),
        .crc  (crc_val)
    );

    assign bit_out   = active & ser_bit;
    assign bit_vld   = active;
    assign fifo_rd   = pop;
    assign sync_sent = sync_now;
    assign pkt_done  = done_now;
    assign underflow = (st_q.phase == PH_UFLOW);

    // R10: underflow holds until a flush
    a_r10_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush) |=> underflow);
    // R10: nothing is read while stalled
    a_r10_no_read_in_uflow: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> !fifo_rd);
    // R12: reads only hit a FIFO that holds data
    a_r12_read_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);
    // R9: the stream stops right after the final bit
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && !flush) |=> !bit_vld);
    // R11: no gap inside a packet except at an underflow
    a_r11_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !pkt_done && !flush) |=> (bit_vld || underflow));
    // R4: sync_sent is a single-cycle pulse
    a_r4_sync_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sent |=> !sync_sent);
    // R8: checksum bytes never pull from the FIFO
    a_r8_crc_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CRC) |-> !fifo_rd);

endmodule

// File: tb/tb_txf_framer.sv
module tb_txf_framer;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 4;
    localparam int LEN_W      = 8;
    localparam int MAXB       = 4096;
    localparam int NV         = 6;

    typedef struct packed {
        logic [3:0]  pre;
        logic [1:0]  mode;
        logic [7:0]  len;
        logic        crc;
        logic        dbl;
        logic [15:0] sync;
        logic [7:0]  late;
    } vec_t;

    // pre, mode, len, crc, dbl, sync, bit index at which FIFO data arrives (0 = before start)
    localparam vec_t VECS [NV] = '{
        '{4'd3, 2'd0, 8'd5, 1'b1, 1'b0, 16'hD391, 8'd0},
        '{4'd2, 2'd1, 8'd7, 1'b1, 1'b1, 16'h1234, 8'd0},
        '{4'd0, 2'd0, 8'd1, 1'b0, 1'b0, 16'hBEEF, 8'd0},
        '{4'd2, 2'd1, 8'd0, 1'b1, 1'b0, 16'h5A0F, 8'd0},
        '{4'd2, 2'd0, 8'd4, 1'b0, 1'b0, 16'hC3C3, 8'd45},
        '{4'd4, 2'd1, 8'd3, 1'b0, 1'b1, 16'h8001, 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, flush = 1'b0;
    logic [PRE_W-1:0] cfg_pre_bytes = '0;
    logic [15:0]      cfg_sync = '0;
    logic             cfg_sync_dbl = 1'b0, cfg_crc_en = 1'b0;
    logic [1:0]       cfg_len_mode = '0;
    logic [LEN_W-1:0] cfg_pkt_len = '0;
    logic fifo_rd, bit_out, bit_vld, sync_sent, pkt_done, underflow;

    logic [7:0] fmem [0:511];
    int head = 0, tail = 0;
    logic       fifo_empty;
    logic [7:0] fifo_data;
    assign fifo_empty = (head == tail);
    assign fifo_data  = fmem[head[8:0]];

    int n_chk = 0, n_bad = 0;

    logic cap [0:MAXB-1];
    int nbits = 0, sync_at = -1, done_at = -1, first_cyc = -1, last_cyc = -1, cyc = 0;

    logic [7:0] pbuf [0:511];
    int np = 0;
    logic [7:0] ebytes [0:511];
    int ne = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (fifo_rd) head <= head + 1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (bit_vld) begin
            if (nbits < MAXB) cap[nbits] = bit_out;
            if (sync_sent) sync_at = nbits;
            if (pkt_done)  done_at = nbits;
            if (first_cyc < 0) first_cyc = cyc;
            last_cyc = cyc;
            nbits = nbits + 1;
        end
    end

    txf_framer #(.PRE_W(PRE_W), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .flush(flush),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync(cfg_sync), .cfg_sync_dbl(cfg_sync_dbl),
        .cfg_len_mode(cfg_len_mode), .cfg_pkt_len(cfg_pkt_len), .cfg_crc_en(cfg_crc_en),
        .bit_out(bit_out), .bit_vld(bit_vld), .sync_sent(sync_sent),
        .pkt_done(pkt_done), .underflow(underflow)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [7:0] gen(input int s, input int i);
        return 8'((s * 37) + (i * 13) + 5);
    endfunction

    function automatic logic [15:0] crc_ref(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int b = 0; b < n; b++)
            for (int i = 7; i >= 0; i--)
                c = (c[15] ^ pbuf[b][i]) ? ({c[14:0], 1'b0} ^ 16'h8005) : {c[14:0], 1'b0};
        return c;
    endfunction

    task automatic mon_clear();
        nbits = 0; sync_at = -1; done_at = -1; first_cyc = -1; last_cyc = -1;
    endtask

    task automatic push_all();
        for (int i = 0; i < np; i++) begin
            fmem[tail[8:0]] = pbuf[i];
            tail = tail + 1;
        end
    endtask

    task automatic pulse_tx();
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk) tx_en = 1'b0;
    endtask

    task automatic build_exp(input int k, input bit dbl, input logic [15:0] sy, input bit crc);
        logic [15:0] c;
        ne = 0;
        for (int i = 0; i < k; i++) begin ebytes[ne] = 8'hAA; ne++; end
        for (int r = 0; r < (dbl ? 2 : 1); r++) begin
            ebytes[ne] = sy[15:8]; ne++;
            ebytes[ne] = sy[7:0];  ne++;
        end
        for (int i = 0; i < np; i++) begin ebytes[ne] = pbuf[i]; ne++; end
        if (crc) begin
            c = crc_ref(np);
            ebytes[ne] = c[15:8]; ne++;
            ebytes[ne] = c[7:0];  ne++;
        end
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); #1;
            if (done_at >= 0) break;
        end
        @(posedge clk); #1;
    endtask

    // compares the captured packet with the image; tag names the length-mode requirement
    task automatic check_pkt(input string tag, input int k, input int nsync, input int pops);
        int mism;
        mism = 0;
        chk(nbits == ne * 8, {tag, " total bit count"}, nbits, ne * 8);
        for (int i = 0; i < ne * 8 && i < nbits; i++)
            if (cap[i] !== ebytes[i / 8][7 - (i % 8)]) mism++;
        chk(mism == 0, "R2 R4 R8 bit content mismatches", mism, 0);
        chk(sync_at == (k + nsync) * 8 - 1, "R4 sync_sent position", sync_at, (k + nsync) * 8 - 1);
        chk(done_at == ne * 8 - 1, "R9 pkt_done position", done_at, ne * 8 - 1);
        chk(bit_vld == 1'b0, "R9 idle after packet", bit_vld, 0);
        chk(last_cyc - first_cyc + 1 == nbits, "R11 no gap in bit_vld", last_cyc - first_cyc + 1, nbits);
        chk(pops == np, "R12 FIFO read count", pops, np);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int h0, k, p1;
        repeat (3) @(negedge clk);
        chk(bit_vld == 0 && fifo_rd == 0, "R1 reset outputs idle", {bit_vld, fifo_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({bit_vld, fifo_rd, sync_sent, pkt_done, underflow} == 5'b0, "R1 state after reset",
            {bit_vld, fifo_rd, sync_sent, pkt_done, underflow}, 0);

        // table of packets
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            np = 0;
            if (t.mode == 2'd1) begin pbuf[np] = t.len; np++; end
            for (int i = 0; i < int'(t.len); i++) begin pbuf[np] = gen(v, i); np++; end
            @(negedge clk);
            cfg_pre_bytes = t.pre; cfg_len_mode = t.mode; cfg_pkt_len = t.len;
            cfg_crc_en = t.crc; cfg_sync_dbl = t.dbl; cfg_sync = t.sync;
            mon_clear();
            h0 = head;
            if (t.late == 0) push_all();
            pulse_tx();
            if (t.late != 0) begin
                for (int i = 0; i < 2000; i++) begin
                    @(posedge clk); #1;
                    if (nbits == int'(t.late) - 1) break;
                end
                push_all();   // R3: data arrives mid-preamble
            end
            p1 = (t.pre == 0) ? 1 : int'(t.pre);
            k  = p1;
            if (t.late != 0 && (int'(t.late) + 7) / 8 > k) k = (int'(t.late) + 7) / 8;
            wait_done(3000);
            build_exp(k, t.dbl, t.sync, t.crc);
            check_pkt((t.mode == 2'd1) ? "R6 variable" : ((t.late != 0) ? "R3 late data" : "R5 fixed"),
                      k, t.dbl ? 4 : 2, head - h0);
        end

        // R7: endless packet switched to fixed length mid-packet, 300 bytes, stop at 300 mod 256
        np = 0;
        for (int i = 0; i < 300; i++) begin pbuf[np] = gen(9, i); np++; end
        @(negedge clk);
        cfg_pre_bytes = 4'd2; cfg_len_mode = 2'd2; cfg_pkt_len = 8'd44;
        cfg_crc_en = 1'b1; cfg_sync_dbl = 1'b0; cfg_sync = 16'h7E81;
        mon_clear(); h0 = head; push_all();
        pulse_tx();
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            if (nbits >= (2 + 2 + 266) * 8) break;
        end
        cfg_len_mode = 2'd0;
        wait_done(4000);
        build_exp(2, 1'b0, 16'h7E81, 1'b1);
        check_pkt("R7 endless to fixed", 2, 2, head - h0);

        // R10: underflow, sticky, writes and tx_en ignored, flush clears
        np = 0;
        for (int i = 0; i < 4; i++) begin pbuf[np] = gen(11, i); np++; end
        @(negedge clk);
        cfg_pre_bytes = 4'd2; cfg_len_mode = 2'd0; cfg_pkt_len = 8'd10;
        cfg_crc_en = 1'b0; cfg_sync = 16'h2DD4;
        mon_clear(); h0 = head; push_all();
        pulse_tx();
        for (int i = 0; i < 500; i++) begin
            @(posedge clk); #1;
            if (underflow) break;
        end
        @(negedge clk);
        chk(underflow == 1'b1, "R10 underflow raised", underflow, 1);
        chk(bit_vld == 1'b0, "R10 stream stopped", bit_vld, 0);
        chk(nbits == 64, "R10 bits before underflow", nbits, 64);
        np = 0;
        for (int i = 0; i < 6; i++) begin pbuf[np] = gen(12, i); np++; end
        push_all();
        pulse_tx();
        repeat (30) @(negedge clk);
        chk(underflow == 1'b1, "R10 underflow sticky after writes", underflow, 1);
        chk(nbits == 64, "R10 no restart after writes", nbits, 64);
        chk(head - h0 == 4, "R10 no reads while stalled", head - h0, 4);
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        chk(underflow == 1'b0, "R10 flush clears underflow", underflow, 0);
        chk(bit_vld == 1'b0, "R10 idle after flush", bit_vld, 0);
        cfg_pkt_len = 8'd6;
        mon_clear(); h0 = head;
        pulse_tx();
        wait_done(2000);
        build_exp(2, 1'b0, 16'h2DD4, 1'b0);
        check_pkt("R5 restart after flush", 2, 2, head - h0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule